// File: doc/BRIEF.md
# Segmented Address Translation Unit

This unit turns a 16-bit virtual address into a 16-bit physical address through a four-entry segment table held in flip-flops. The two top address bits pick an entry, and the remaining fourteen bits are an offset into that segment. Each entry stores a base, a limit, a present flag and a store-permission flag. The physical address is the base plus the offset. The offset must be below the limit, the entry must be present, and a store needs the permission flag.

A privileged configuration port loads one whole entry per clock. The lookup port takes a request strobe, an address and an access kind. One cycle later it returns a response strobe, the physical address and a two-bit fault code. Lookups never change the table. Any fault forces the returned address to zero.

Top module: `seg_xlate`

## Requirements
- R1: After reset every table entry is absent, so any lookup returns fault 01 with physical address 0, and no response is flagged until a request arrives.
- R2: Virtual address bits 15:14 select the entry, and bits 13:0 are the offset.
- R3: A fault-free response carries base plus the zero-extended offset, taken modulo 2^16, with no separate overflow flag.
- R4: A present entry whose offset is greater than or equal to its limit returns fault 10 (bounds).
- R5: An absent entry returns fault 01, whatever the offset and the access kind.
- R6: Access kind 10 (store) to a present, in-bounds entry whose store-permission flag is clear returns fault 11. Kinds 00 (fetch), 01 (load) and 11 (treated as load) never return fault 11. Bounds takes priority over permission.
- R7: Whenever the fault code is nonzero, the physical address output is 0.
- R8: The response strobe is high exactly one cycle after the request strobe. Without a response, the address and fault outputs are 0.
- R9: On a clock edge with the configuration write enable high, the selected entry takes the new base, limit, present and permission values, and the other entries keep theirs. A lookup in that same cycle sees the old entry.
- R10: With entry 0 at base 0x4000, limit 0x0800, virtual 0x0240 maps to 0x4240. With entry 1 at base 0x4800, limit 0x1400, virtual 0x4050 maps to 0x4850.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Privileged write enable for one table entry |
| cfg_sel | input | 2 | Entry being written |
| cfg_base | input | 16 | New base |
| cfg_limit | input | 15 | New limit (0 to 0x4000) |
| cfg_present | input | 1 | New present flag |
| cfg_writable | input | 1 | New store-permission flag |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 16 | Virtual address |
| req_kind | input | 2 | 00 fetch, 01 load, 10 store, 11 load |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_paddr | output | 16 | Physical address, 0 on a fault |
| rsp_fault | output | 2 | 00 ok, 01 absent, 10 bounds, 11 protection |

## Verification
The bench sweeps every entry with offsets spread over the whole range, plus limit-1, limit and limit+1, under each access kind. An off-by-one bound would pass or fault the offset equal to the limit. Tables with a zero limit, a full 0x4000 limit and a base near 0xFFF0 exercise limits that block everything and sums that wrap. A wrong fault priority would show up as a permission fault on an absent or out-of-bounds store. A write and a lookup on the same entry in the same cycle shows whether the lookup reads the old entry or bypasses to the new one.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int VA_W     = 16,
  parameter int SEG_BITS = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [SEG_BITS-1:0]   cfg_sel,
  input  logic [VA_W-1:0]       cfg_base,
  input  logic [VA_W-SEG_BITS:0] cfg_limit,
  input  logic                  cfg_present,
  input  logic                  cfg_writable,
  input  logic                  req_valid,
  input  logic [VA_W-1:0]       req_addr,
  input  logic [1:0]            req_kind,
  output logic                  rsp_valid,
  output logic [VA_W-1:0]       rsp_paddr,
  output logic [1:0]            rsp_fault
);
  localparam int OFF_W = VA_W - SEG_BITS;
  localparam int LIM_W = OFF_W + 1;
  localparam int NSEG  = 1 << SEG_BITS;

  localparam logic [1:0] F_OK = 2'b00, F_ABSENT = 2'b01, F_BOUND = 2'b10, F_PROT = 2'b11;
  localparam logic [1:0] K_STORE = 2'b10;

  logic [NSEG-1:0][VA_W-1:0]  base_q;
  logic [NSEG-1:0][LIM_W-1:0] lim_q;
  logic [NSEG-1:0]            pres_q, wok_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      lim_q  <= '0;
      pres_q <= '0;
      wok_q  <= '0;
    end else if (cfg_we) begin
      base_q[cfg_sel] <= cfg_base;
      lim_q[cfg_sel]  <= cfg_limit;
      pres_q[cfg_sel] <= cfg_present;
      wok_q[cfg_sel]  <= cfg_writable;
    end
  end

  wire [SEG_BITS-1:0] seg = req_addr[VA_W-1 -: SEG_BITS];
  wire [OFF_W-1:0]    off = req_addr[OFF_W-1:0];
  wire [VA_W-1:0]     sum = base_q[seg] + VA_W'(off);

  logic [1:0] fault;
  always_comb begin
    if (!pres_q[seg])                            fault = F_ABSENT;
    else if (LIM_W'(off) >= lim_q[seg])          fault = F_BOUND;
    else if (req_kind == K_STORE && !wok_q[seg]) fault = F_PROT;
    else                                         fault = F_OK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_fault <= F_OK;
    end else begin
      rsp_valid <= req_valid;
      rsp_fault <= req_valid ? fault : F_OK;
      rsp_paddr <= (req_valid && fault == F_OK) ? sum : '0;
    end
  end

  assert_lat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && rsp_fault == F_OK && rsp_paddr == '0));
  assert_zero_on_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault != F_OK |-> rsp_paddr == '0);
  assert_prot_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault == F_PROT |-> $past(req_kind) == K_STORE);
  assert_absent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !pres_q[seg]) |=> rsp_fault == F_ABSENT);
  assert_table_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(base_q) && $stable(lim_q) && $stable(pres_q) && $stable(wok_q)));
endmodule

// File: tb/tb_seg_xlate.sv
module tb_seg_xlate;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_present = 0, cfg_writable = 0;
  logic [1:0] cfg_sel = 0;
  logic [15:0] cfg_base = 0;
  logic [14:0] cfg_limit = 0;
  logic req_valid = 0;
  logic [15:0] req_addr = 0;
  logic [1:0] req_kind = 0;
  logic rsp_valid;
  logic [15:0] rsp_paddr;
  logic [1:0] rsp_fault;

  int n_run = 0, n_fail = 0;

  logic [15:0] m_base [4];
  logic [14:0] m_lim [4];
  logic m_pres [4], m_wok [4];

  seg_xlate dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic void model(input logic [15:0] a, input logic [1:0] k,
                                output logic [15:0] p, output logic [1:0] f);
    int s = a[15:14];
    logic [14:0] off = {1'b0, a[13:0]};
    if (!m_pres[s])                    f = 2'b01;
    else if (off >= m_lim[s])          f = 2'b10;
    else if (k == 2'b10 && !m_wok[s])  f = 2'b11;
    else                               f = 2'b00;
    p = (f == 2'b00) ? 16'(m_base[s] + {2'b0, a[13:0]}) : 16'h0;
  endfunction

  task automatic put(input int s, input logic [15:0] b, input logic [14:0] l,
                     input logic v, input logic w);
    @(negedge clk);
    cfg_we = 1; cfg_sel = 2'(s); cfg_base = b; cfg_limit = l;
    cfg_present = v; cfg_writable = w;
    @(negedge clk);
    cfg_we = 0;
    m_base[s] = b; m_lim[s] = l; m_pres[s] = v; m_wok[s] = w;
  endtask

  task automatic look(input logic [15:0] a, input logic [1:0] k, input string r);
    logic [15:0] ep;
    logic [1:0] ef;
    model(a, k, ep, ef);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_kind = k;
    @(negedge clk);
    req_valid = 0;
    n_run++;
    if (!(rsp_valid === 1'b1 && rsp_paddr === ep && rsp_fault === ef)) begin
      n_fail++;
      $display("FAIL %s addr=%h kind=%0d got v=%b pa=%h f=%b exp v=1 pa=%h f=%b",
               r, a, k, rsp_valid, rsp_paddr, rsp_fault, ep, ef);
    end
  endtask

  task automatic sweep(input string r);
    for (int s = 0; s < 4; s++) begin
      for (int i = 0; i < 68; i++) begin
        int o;
        if (i < 64)       o = i * 257;
        else if (i == 64) o = int'(m_lim[s]) - 1;
        else if (i == 65) o = int'(m_lim[s]);
        else if (i == 66) o = int'(m_lim[s]) + 1;
        else              o = 16'h3FFF;
        o = o & 16'h3FFF;
        for (int k = 0; k < 4; k++)
          look(16'((s << 14) | o), 2'(k), r);
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int s = 0; s < 4; s++) begin
      m_base[s] = 0; m_lim[s] = 0; m_pres[s] = 0; m_wok[s] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    n_run++;
    if (rsp_valid !== 1'b0 || rsp_paddr !== 16'h0 || rsp_fault !== 2'b00) begin
      n_fail++;
      $display("FAIL R1 idle after reset got v=%b pa=%h f=%b exp v=0 pa=0000 f=00",
               rsp_valid, rsp_paddr, rsp_fault);
    end
    sweep("R1 all absent after reset");

    put(0, 16'h4000, 15'h0800, 1, 0);
    put(1, 16'h4800, 15'h1400, 1, 1);
    put(2, 16'hF000, 15'h1000, 1, 0);
    put(3, 16'h0000, 15'h3000, 1, 1);
    look(16'h0240, 2'b00, "R10 fetch 0x0240");
    look(16'h4050, 2'b01, "R10 load 0x4050");
    look(16'h0240, 2'b10, "R6 store to read-only");
    sweep("R2 R3 R4 R6 R7 table A");

    // idle cycle: no response expected
    @(negedge clk);
    n_run++;
    if (rsp_valid !== 1'b0 || rsp_paddr !== 16'h0 || rsp_fault !== 2'b00) begin
      n_fail++;
      $display("FAIL R8 idle got v=%b pa=%h f=%b exp v=0 pa=0000 f=00",
               rsp_valid, rsp_paddr, rsp_fault);
    end

    put(0, 16'h1234, 15'h2000, 0, 1);
    put(1, 16'h4000, 15'h0000, 1, 1);
    put(2, 16'hFFF0, 15'h4000, 1, 1);
    put(3, 16'h8000, 15'h4000, 0, 0);
    sweep("R3 R4 R5 table B wrap and extreme limits");

    put(1, 16'h1000, 15'h0100, 1, 0);
    // same-cycle write and lookup on entry 1: lookup sees old entry
    @(negedge clk);
    cfg_we = 1; cfg_sel = 2'd1; cfg_base = 16'h2000; cfg_limit = 15'h0100;
    cfg_present = 1; cfg_writable = 1;
    req_valid = 1; req_addr = 16'h4010; req_kind = 2'b10;
    @(negedge clk);
    cfg_we = 0; req_valid = 0;
    n_run++;
    if (rsp_valid !== 1'b1 || rsp_fault !== 2'b11 || rsp_paddr !== 16'h0) begin
      n_fail++;
      $display("FAIL R9 same-cycle old entry got v=%b pa=%h f=%b exp v=1 pa=0000 f=11",
               rsp_valid, rsp_paddr, rsp_fault);
    end
    m_base[1] = 16'h2000; m_wok[1] = 1;
    look(16'h4010, 2'b10, "R9 new entry after write");
    look(16'h0010, 2'b01, "R9 other entry unchanged");
    look(16'hC010, 2'b01, "R9 other entry unchanged");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule